// File: doc/BRIEF.md
# USB FIFO to JTAG Command Engine

This block connects a parallel USB receive/transmit FIFO to a JTAG probe header. It is the clock master: it pulls each command byte out of the FIFO with a read strobe, decodes it, drives the JTAG pins, and pushes any captured TDO data back through the FIFO's write side. The host never drives the JTAG pins directly; nothing reaches them unless the engine fetched it.

Every command byte is one of two kinds, chosen by its top bit. A pin-update byte sets TCK, TMS, TDI, two auxiliary chip-select lines and the pin-driver enable in one step, and may ask for a single TDO sample to be sent back. A shift header announces a run of up to 63 data bytes. Each of these is serialised onto TDI with eight TCK pulses at a fixed rate, while TMS is held. The header can also ask for TDO to be gathered into one returned byte per data byte. Pin-update bytes give fine control for TAP state moves. Shift runs carry long scan data at full TCK rate.

Top module: `jtag_fifo_engine`

## Requirements
- R1: While reset is asserted and until the first command, jtag_oe, led, jtag_tck, jtag_tms, jtag_tdi, jtag_nce and jtag_ncs are 0, and neither fifo_rd nor fifo_wr is asserted, even if the FIFO holds data.
- R2: fifo_rd is pulsed only while fifo_rx_empty is 0. Each cycle with fifo_rd high consumes the byte on fifo_rdata in that cycle. No byte is fetched while a data byte is still being shifted: all 8 TCK pulses finish first.
- R3: A command byte with bit 7 clear is a pin update. From the cycle after it is taken, jtag_tck = bit 0, jtag_tms = bit 1, jtag_nce = bit 2, jtag_ncs = bit 3 and jtag_tdi = bit 4, and they hold until the next pin update.
- R4: Bit 5 of a pin-update byte is the driver enable. jtag_oe and led both equal it from the cycle after the byte is taken. While it is 0 the header pins are to be treated as high impedance.
- R5: A pin-update byte with bit 6 set returns one byte through the write side. Bit 0 of that byte is jtag_tdo as sampled on the clock edge that takes the command, and bits 7..1 are 0.
- R6: A command byte with bit 7 set is a shift header. Bits 5..0 give the number N of data bytes that follow, and bit 6 requests capture. With N = 0 no TCK pulse is produced and the next byte is a command.
- R7: Each data byte gives exactly 8 TCK pulses starting from TCK low. TDI carries the byte least significant bit first, changing only while TCK is low, and is stable at each rising edge. TMS, nCE, nCS and the driver enable do not change during the shift.
- R8: In a shift, each TCK low phase and each high phase lasts CLK_HZ/(2*TCK_HZ) clock cycles, which is 16 with the defaults (200 MHz clock, 6 MHz TCK). The first low phase is counted from the cycle the data byte is taken.
- R9: With capture requested, each data byte returns one byte. Its bit k is jtag_tdo sampled at the k-th TCK rising edge of that byte (LSB first).
- R10: fifo_wr is pulsed only while fifo_tx_full is 0. The engine waits with the pending byte while the FIFO is full, and returned bytes leave in the order of the commands that requested them.
- R11: Once all N data bytes of a shift run are done, the next byte fetched is decoded as a command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fifo_rx_empty | input | 1 | High while the FIFO has no byte for the engine |
| fifo_rdata | input | 8 | Byte at the head of the receive FIFO |
| fifo_rd | output | 1 | Read strobe; the head byte is consumed in each cycle it is high |
| fifo_tx_full | input | 1 | High while the FIFO cannot accept a returned byte |
| fifo_wdata | output | 8 | Returned byte, valid with fifo_wr |
| fifo_wr | output | 1 | Write strobe for the returned byte |
| jtag_tck | output | 1 | Test clock |
| jtag_tms | output | 1 | Test mode select |
| jtag_tdi | output | 1 | Test data toward the target |
| jtag_nce | output | 1 | Auxiliary active-low chip-enable line |
| jtag_ncs | output | 1 | Auxiliary active-low chip-select line |
| jtag_tdo | input | 1 | Test data from the target |
| jtag_oe | output | 1 | Pin-driver enable |
| led | output | 1 | Activity indicator, follows the driver enable |

## Verification
The bench targets places where the two modes meet. One case is a pin update that leaves TCK high just before a shift run, where a wrong design would start its first pulse without a low phase or would shift the wrong bit. Another is a header with a zero count, where a wrong design would swallow the following command as data and produce stray TCK pulses. A maximum-length run of 63 bytes exposes a truncated count field. Back-pressure on both FIFO sides checks that a stalled write-back neither drops nor reorders returned bytes, and that no byte is fetched while eight pulses are still pending. A single-bit TDO pattern that changes on every TCK fall shows up any bit-order reversal or sampling on the wrong edge as a wrong returned byte.

// File: rtl/jfe_pkg.sv
`timescale 1ns/1ps
package jfe_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 6;

  // command byte bit positions (decoded by the engine)
  localparam int B_TCK  = 0;
  localparam int B_TMS  = 1;
  localparam int B_NCE  = 2;
  localparam int B_NCS  = 3;
  localparam int B_TDI  = 4;
  localparam int B_OE   = 5;
  localparam int B_RD   = 6;
  localparam int B_MODE = 7;

  typedef struct packed {
    logic oe;
    logic tdi;
    logic ncs;
    logic nce;
    logic tms;
    logic tck;
  } pins_t;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_CMD,
    ST_BB_WB,
    ST_FETCH,
    ST_SHIFT,
    ST_SH_WB
  } eng_st_t;
endpackage

// File: rtl/jfe_decode.sv
`timescale 1ns/1ps
module jfe_decode
  import jfe_pkg::*;
(
  input  logic [BYTE_W-1:0] cmd_i,
  output logic              is_hdr_o,
  output logic              want_rd_o,
  output logic [CNT_W-1:0]  count_o,
  output pins_t             pins_o
);
  always_comb begin
    is_hdr_o    = cmd_i[B_MODE];
    want_rd_o   = cmd_i[B_RD];
    count_o     = cmd_i[CNT_W-1:0];
    pins_o.tck  = cmd_i[B_TCK];
    pins_o.tms  = cmd_i[B_TMS];
    pins_o.nce  = cmd_i[B_NCE];
    pins_o.ncs  = cmd_i[B_NCS];
    pins_o.tdi  = cmd_i[B_TDI];
    pins_o.oe   = cmd_i[B_OE];
  end
endmodule

// File: rtl/jfe_shifter.sv
`timescale 1ns/1ps
module jfe_shifter
  import jfe_pkg::*;
#(
  parameter int HALF = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              tdo_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              tck_o,
  output logic              tdi_o,
  output logic [BYTE_W-1:0] cap_o
);
  localparam int HC_W  = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [HC_W-1:0]  HC_LAST  = HC_W'(HALF - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

  logic              busy_q, busy_d;
  logic              hi_q, hi_d;
  logic [HC_W-1:0]   hc_q, hc_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [BYTE_W-1:0] sr_q, sr_d;
  logic [BYTE_W-1:0] cap_q, cap_d;
  logic              tck_q, tck_d;
  logic              tdi_q, tdi_d;
  logic              done_q, done_d;

  always_comb begin
    busy_d = busy_q;
    hi_d   = hi_q;
    hc_d   = hc_q;
    bit_d  = bit_q;
    sr_d   = sr_q;
    cap_d  = cap_q;
    tck_d  = tck_q;
    tdi_d  = tdi_q;
    done_d = 1'b0;
    if (load_i) begin
      busy_d = 1'b1;
      hi_d   = 1'b0;
      hc_d   = '0;
      bit_d  = '0;
      sr_d   = data_i;
      tck_d  = 1'b0;
      tdi_d  = data_i[0];
    end else if (busy_q) begin
      if (hc_q == HC_LAST) begin
        hc_d = '0;
        if (!hi_q) begin
          // rising edge: sample target output
          tck_d = 1'b1;
          hi_d  = 1'b1;
          cap_d = {tdo_i, cap_q[BYTE_W-1:1]};
        end else begin
          // falling edge: present next data bit
          tck_d = 1'b0;
          hi_d  = 1'b0;
          if (bit_q == BIT_LAST) begin
            busy_d = 1'b0;
            done_d = 1'b1;
          end else begin
            bit_d = bit_q + BIT_W'(1);
            sr_d  = sr_q >> 1;
            tdi_d = sr_q[1];
          end
        end
      end else begin
        hc_d = hc_q + HC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hi_q   <= 1'b0;
      hc_q   <= '0;
      bit_q  <= '0;
      sr_q   <= '0;
      cap_q  <= '0;
      tck_q  <= 1'b0;
      tdi_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      hi_q   <= hi_d;
      hc_q   <= hc_d;
      bit_q  <= bit_d;
      sr_q   <= sr_d;
      cap_q  <= cap_d;
      tck_q  <= tck_d;
      tdi_q  <= tdi_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign tck_o  = tck_q;
  assign tdi_o  = tdi_q;
  assign cap_o  = cap_q;
endmodule

// File: rtl/jfe_ctrl.sv
`timescale 1ns/1ps
module jfe_ctrl
  import jfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_empty_i,
  input  logic [BYTE_W-1:0] rdata_i,
  input  logic              tx_full_i,
  input  logic              tdo_i,
  input  logic              sh_done_i,
  input  logic [BYTE_W-1:0] sh_cap_i,
  output logic              rd_o,
  output logic              wr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              sh_load_o,
  output pins_t             pins_o,
  output logic              use_sh_o,
  output logic              in_cmd_o
);
  eng_st_t           st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              rdf_q, rdf_d;
  logic [BYTE_W-1:0] wb_q, wb_d;
  pins_t             pins_q, pins_d;
  logic              use_sh_q, use_sh_d;

  logic              dec_hdr;
  logic              dec_rd;
  logic [CNT_W-1:0]  dec_cnt;
  pins_t             dec_pins;
  logic              cnt_last;

  jfe_decode u_dec (
    .cmd_i     (rdata_i),
    .is_hdr_o  (dec_hdr),
    .want_rd_o (dec_rd),
    .count_o   (dec_cnt),
    .pins_o    (dec_pins)
  );

  always_comb begin
    in_cmd_o  = (st_q == ST_CMD);
    rd_o      = ((st_q == ST_CMD) || (st_q == ST_FETCH)) && !rx_empty_i;
    wr_o      = ((st_q == ST_BB_WB) || (st_q == ST_SH_WB)) && !tx_full_i;
    sh_load_o = (st_q == ST_FETCH) && !rx_empty_i;
    cnt_last  = (cnt_q == CNT_W'(1));
  end

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    rdf_d    = rdf_q;
    wb_d     = wb_q;
    pins_d   = pins_q;
    use_sh_d = use_sh_q;
    unique case (st_q)
      ST_BOOT: st_d = ST_CMD;
      ST_CMD: begin
        if (rd_o) begin
          if (dec_hdr) begin
            cnt_d = dec_cnt;
            rdf_d = dec_rd;
            if (dec_cnt != '0) st_d = ST_FETCH;
          end else begin
            pins_d   = dec_pins;
            use_sh_d = 1'b0;
            if (dec_rd) begin
              wb_d = {{(BYTE_W-1){1'b0}}, tdo_i};
              st_d = ST_BB_WB;
            end
          end
        end
      end
      ST_BB_WB: begin
        if (wr_o) st_d = ST_CMD;
      end
      ST_FETCH: begin
        if (rd_o) begin
          use_sh_d = 1'b1;
          st_d     = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (sh_done_i) begin
          if (rdf_q) begin
            wb_d = sh_cap_i;
            st_d = ST_SH_WB;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
            st_d  = cnt_last ? ST_CMD : ST_FETCH;
          end
        end
      end
      ST_SH_WB: begin
        if (wr_o) begin
          cnt_d = cnt_q - CNT_W'(1);
          st_d  = cnt_last ? ST_CMD : ST_FETCH;
        end
      end
      default: st_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_BOOT;
      cnt_q    <= '0;
      rdf_q    <= 1'b0;
      wb_q     <= '0;
      pins_q   <= '0;
      use_sh_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      rdf_q    <= rdf_d;
      wb_q     <= wb_d;
      pins_q   <= pins_d;
      use_sh_q <= use_sh_d;
    end
  end

  assign wdata_o  = wb_q;
  assign pins_o   = pins_q;
  assign use_sh_o = use_sh_q;
endmodule

// File: rtl/jtag_fifo_engine.sv
`timescale 1ns/1ps
module jtag_fifo_engine
  import jfe_pkg::*;
#(
  parameter int CLK_HZ      = 200_000_000,
  parameter int TCK_HZ      = 6_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_rx_empty,
  input  logic [BYTE_W-1:0] fifo_rdata,
  output logic              fifo_rd,
  input  logic              fifo_tx_full,
  output logic [BYTE_W-1:0] fifo_wdata,
  output logic              fifo_wr,
  output logic              jtag_tck,
  output logic              jtag_tms,
  output logic              jtag_tdi,
  output logic              jtag_nce,
  output logic              jtag_ncs,
  input  logic              jtag_tdo,
  output logic              jtag_oe,
  output logic              led
);
  localparam int HALF_RAW = CLK_HZ / (2 * TCK_HZ);
  localparam int HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;

  // reset: asserted asynchronously, released through a synchroniser
  logic [SYNC_STAGES-1:0] rs_q;
  logic                   rst_core_n;

  generate
    if (SYNC_STAGES == 1) begin : g_rs1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= 1'b1;
      end
    end else begin : g_rsn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_core_n = rs_q[SYNC_STAGES-1];

  logic              sh_load;
  logic              sh_busy;
  logic              sh_done;
  logic              sh_tck;
  logic              sh_tdi;
  logic [BYTE_W-1:0] sh_cap;
  pins_t             bb_pins;
  logic              use_sh;
  logic              in_cmd;

  jfe_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .rx_empty_i (fifo_rx_empty),
    .rdata_i    (fifo_rdata),
    .tx_full_i  (fifo_tx_full),
    .tdo_i      (jtag_tdo),
    .sh_done_i  (sh_done),
    .sh_cap_i   (sh_cap),
    .rd_o       (fifo_rd),
    .wr_o       (fifo_wr),
    .wdata_o    (fifo_wdata),
    .sh_load_o  (sh_load),
    .pins_o     (bb_pins),
    .use_sh_o   (use_sh),
    .in_cmd_o   (in_cmd)
  );

  jfe_shifter #(.HALF(HALF)) u_shift (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .load_i (sh_load),
    .data_i (fifo_rdata),
    .tdo_i  (jtag_tdo),
    .busy_o (sh_busy),
    .done_o (sh_done),
    .tck_o  (sh_tck),
    .tdi_o  (sh_tdi),
    .cap_o  (sh_cap)
  );

  always_comb begin
    jtag_tck = use_sh ? sh_tck : bb_pins.tck;
    jtag_tdi = use_sh ? sh_tdi : bb_pins.tdi;
    jtag_tms = bb_pins.tms;
    jtag_nce = bb_pins.nce;
    jtag_ncs = bb_pins.ncs;
    jtag_oe  = bb_pins.oe;
    led      = bb_pins.oe;
  end
endmodule

// File: rtl/jfe_checker.sv
`timescale 1ns/1ps
module jfe_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_rx_empty,
  input logic [7:0] fifo_rdata,
  input logic       fifo_rd,
  input logic       fifo_tx_full,
  input logic       fifo_wr,
  input logic       jtag_tck,
  input logic       jtag_tms,
  input logic       jtag_tdi,
  input logic       jtag_nce,
  input logic       jtag_ncs,
  input logic       jtag_oe,
  input logic       sh_busy,
  input logic       in_cmd
);
  assert_rd_avail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_rx_empty);

  assert_rd_quiet_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sh_busy |-> !fifo_rd);

  assert_wr_room_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> !fifo_tx_full);

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_rd && fifo_wr));

  assert_bb_pins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd && in_cmd && !fifo_rdata[7]) |=>
      (jtag_tck == $past(fifo_rdata[0]) && jtag_tms == $past(fifo_rdata[1]) &&
       jtag_nce == $past(fifo_rdata[2]) && jtag_ncs == $past(fifo_rdata[3]) &&
       jtag_tdi == $past(fifo_rdata[4])));

  assert_bb_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd && in_cmd && !fifo_rdata[7]) |=> (jtag_oe == $past(fifo_rdata[5])));

  assert_shift_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_busy && $past(sh_busy)) |-> ($stable(jtag_tms) && $stable(jtag_oe) &&
                                     $stable(jtag_nce) && $stable(jtag_ncs)));
endmodule

bind jtag_fifo_engine jfe_checker u_jfe_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .fifo_rx_empty (fifo_rx_empty),
  .fifo_rdata    (fifo_rdata),
  .fifo_rd       (fifo_rd),
  .fifo_tx_full  (fifo_tx_full),
  .fifo_wr       (fifo_wr),
  .jtag_tck      (jtag_tck),
  .jtag_tms      (jtag_tms),
  .jtag_tdi      (jtag_tdi),
  .jtag_nce      (jtag_nce),
  .jtag_ncs      (jtag_ncs),
  .jtag_oe       (jtag_oe),
  .sh_busy       (sh_busy),
  .in_cmd        (in_cmd)
);

// File: tb/jtag_fifo_engine_bench.sv
`timescale 1ns/1ps
module jtag_fifo_engine_bench;
  localparam int HALF = 200_000_000 / (2 * 6_000_000);
  localparam int WATCHDOG_CYC = 150_000;

  logic       clk;
  logic       rst_n;
  logic       fifo_rx_empty;
  logic [7:0] fifo_rdata;
  logic       fifo_rd;
  logic       fifo_tx_full;
  logic [7:0] fifo_wdata;
  logic       fifo_wr;
  logic       jtag_tck, jtag_tms, jtag_tdi, jtag_nce, jtag_ncs, jtag_oe, led;
  logic       jtag_tdo;

  jtag_fifo_engine u_jtag_fifo_engine (
    .clk(clk), .rst_n(rst_n),
    .fifo_rx_empty(fifo_rx_empty), .fifo_rdata(fifo_rdata), .fifo_rd(fifo_rd),
    .fifo_tx_full(fifo_tx_full), .fifo_wdata(fifo_wdata), .fifo_wr(fifo_wr),
    .jtag_tck(jtag_tck), .jtag_tms(jtag_tms), .jtag_tdi(jtag_tdi),
    .jtag_nce(jtag_nce), .jtag_ncs(jtag_ncs), .jtag_tdo(jtag_tdo),
    .jtag_oe(jtag_oe), .led(led)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  logic [7:0] rxq[$];
  logic [7:0] expw[$];
  string      expt[$];
  bit         stall_rx = 0;
  bit         stall_tx = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic tdo_of(input int i);
    return ((i * 29 + (i >> 3)) % 3) == 1;
  endfunction

  // reference model state
  int         cyc = 0;
  logic       prev_tck = 1'b0;
  int         tdo_idx = 0;
  int         rem = 0;
  bit         rdf = 0;
  bit         in_data = 0;
  bit         after_run = 0;
  int         rises = 0, falls = 0, ev = 0;
  logic [7:0] cur_data = 0, capb = 0;
  logic [3:0] hold = 0;
  bit         pushed = 0;
  bit         bb_pend = 0;
  logic [7:0] bb_byte = 0;

  initial begin
    jtag_tdo      = 1'b0;
    fifo_rx_empty = 1'b1;
    fifo_rdata    = 8'h00;
    fifo_tx_full  = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      begin
        bit rise, fall, bb_now;
        logic [7:0] b;
        rise = jtag_tck && !prev_tck;
        fall = !jtag_tck && prev_tck;
        prev_tck = jtag_tck;
        if (fall) tdo_idx++;
        jtag_tdo      = tdo_of(tdo_idx);
        fifo_rx_empty = (rxq.size() == 0) || (stall_rx && (cyc % 5 < 2));
        fifo_rdata    = (rxq.size() != 0) ? rxq[0] : 8'h00;
        fifo_tx_full  = stall_tx && (cyc % 7 < 4);
        #1;
        if (!rst_n) begin
          if (cyc > 2) begin
            // R1: quiet while in reset, even with data waiting
            check("R1", "rd in reset", int'(fifo_rd), 0);
            check("R1", "wr in reset", int'(fifo_wr), 0);
            check("R1", "oe/led in reset", int'({jtag_oe, led}), 0);
            check("R1", "pins in reset", int'({jtag_tck, jtag_tms, jtag_tdi, jtag_nce, jtag_ncs}), 0);
          end
        end else begin
          bb_now = bb_pend;
          if (bb_pend) begin
            check(after_run ? "R11" : "R3", "pin tck", int'(jtag_tck), int'(bb_byte[0]));
            check("R3", "pins tms/nce/ncs/tdi",
                  int'({jtag_tms, jtag_nce, jtag_ncs, jtag_tdi}),
                  int'({bb_byte[1], bb_byte[2], bb_byte[3], bb_byte[4]}));
            check("R4", "oe/led", int'({jtag_oe, led}), int'({bb_byte[5], bb_byte[5]}));
            bb_pend = 0;
            after_run = 0;
          end
          if (in_data) begin
            ev++;
            if ({jtag_tms, jtag_nce, jtag_ncs, jtag_oe} != hold)
              check("R7", "hold during shift", int'({jtag_tms, jtag_nce, jtag_ncs, jtag_oe}), int'(hold));
            if (rise) begin
              check("R8", "low phase", ev, HALF);
              check("R7", "pulse count", int'(rises < 8), 1);
              if (rises < 8) begin
                check("R7", "tdi at rise", int'(jtag_tdi), int'(cur_data[rises]));
                capb[rises] = jtag_tdo;
              end
              rises++;
              ev = 0;
            end
            if (fall && rises > 0) begin
              check("R8", "high phase", ev, HALF);
              falls++;
              ev = 0;
            end
            if (rises == 8 && falls == 8 && !pushed) begin
              pushed = 1;
              if (rdf) begin
                expw.push_back(capb);
                expt.push_back("R9");
              end
            end
          end else if (rise && !bb_now) begin
            check("R6", "stray tck pulse", 1, 0);
          end
          if (fifo_rd) begin
            check("R2", "rd while empty", int'(fifo_rx_empty), 0);
            if (in_data)
              check("R2", "fetch before 8 pulses", rises * 16 + falls, 8 * 16 + 8);
            b = rxq.pop_front();
            in_data = 0;
            if (rem > 0) begin
              rem--;
              in_data = 1;
              cur_data = b;
              rises = 0; falls = 0; ev = -1; capb = 0; pushed = 0;
              hold = {jtag_tms, jtag_nce, jtag_ncs, jtag_oe};
              if (rem == 0) after_run = 1;
            end else if (b[7]) begin
              rem = int'(b[5:0]);
              rdf = b[6];
              if (rem == 0) after_run = 1;
            end else begin
              bb_pend = 1;
              bb_byte = b;
              if (b[6]) begin
                expw.push_back({7'b0, jtag_tdo});
                expt.push_back("R5");
              end
            end
          end
          if (fifo_wr) begin
            check("R10", "wr while full", int'(fifo_tx_full), 0);
            if (expw.size() == 0) begin
              check("R10", "unexpected write-back", 1, 0);
            end else begin
              logic [7:0] e;
              string t;
              e = expw.pop_front();
              t = expt.pop_front();
              check(t, "returned byte", int'(fifo_wdata), int'(e));
            end
          end
        end
      end
    end
  end

  task automatic send(input logic [7:0] b);
    rxq.push_back(b);
  endtask

  task automatic drain();
    while (rxq.size() != 0) @(negedge clk);
    repeat (400) @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst_n = 1'b0;
    send(8'h21);              // waiting during reset (R1)
    repeat (8) @(negedge clk);
    rst_n = 1'b1;

    // pin updates, driver enable on and off (R3, R4)
    send(8'h20); send(8'h22); send(8'h3F); send(8'h13); send(8'h2C);
    // pin updates with single-bit reads (R5)
    send(8'h60); send(8'h61); send(8'h60); send(8'h40); send(8'h21);
    drain();

    // leave TCK high, then a shift run without capture (R7, R8, R11)
    send(8'h23);
    send(8'h83); send(8'hA5); send(8'h3C); send(8'hFF);
    send(8'h24);
    // shift with capture (R9)
    send(8'hC2); send(8'h96); send(8'h01);
    // zero-count header then a command (R6)
    send(8'h80); send(8'h27); send(8'h66);
    drain();

    // back-pressure on both sides (R2, R10)
    stall_rx = 1; stall_tx = 1;
    send(8'hC1); send(8'h5A);
    send(8'h60); send(8'h61);
    send(8'hC3); send(8'h0F); send(8'hF0); send(8'h81);
    send(8'h22);
    drain();
    stall_rx = 0; stall_tx = 0;

    // maximum count with capture (R6, R9)
    send(8'hFF);
    for (int i = 0; i < 63; i++) send(8'((i * 37 + 11) & 8'hFF));
    send(8'h32);
    drain();

    check("R10", "all returned bytes seen", expw.size(), 0);
    check("R2", "all bytes consumed", rxq.size(), 0);
    report();
  end
endmodule